// File: doc/BRIEF.md
# Fuzzy Grade Operator Unit

This unit takes two fuzzy membership grades and applies one of five fuzzy operators to them: minimum, maximum, bounded sum, bounded difference or bounded product. Each grade is an N-digit radix-4 number whose digits may take the values 0 to 4. The digit set is redundant, so one grade value can have several valid encodings. Full scale, meaning a grade of 1.0, is the integer value 4^N.

Because the encodings are redundant, the unit does not compare or combine operands digit by digit. It first reduces each operand to its integer value and clamps that value to full scale. It then applies the saturating arithmetic and compares the two operands by value. The result goes back into the same digit form in one canonical encoding.

Operands arrive on a valid/ready stream and results leave on another. A single output register holds one result. An input transfer takes place in any cycle where `in_valid` and `in_ready` are both high. The unit raises `in_ready` whenever the output register is empty or is being emptied in that same cycle. A result holds steady until the consumer takes it with `out_ready`.

Top module: `fz_grade_unit`

## Requirements
- R1: Digit i of an operand sits in bits [3i+2:3i]. The operand's value is the sum of digit_i·4^i, and any digit code above 4 counts as 4. A value above 4^N is clamped to 4^N.
- R2: Operator code 0 returns the smaller of the two grades.
- R3: Operator code 1 returns the larger of the two grades.
- R4: Operator code 2 returns min(4^N, a+b).
- R5: Operator code 3 returns max(0, a−b).
- R6: Operator code 4 returns max(0, a+b−4^N).
- R7: Operator codes 5, 6 and 7 return zero.
- R8: `out_a_larger` is high exactly when value(a) > value(b). `out_tie` is high exactly when the two values are equal, whatever the encodings.
- R9: A result below 4^N is emitted with digits 0..3 only, as plain base 4. Full scale is emitted as top digit 4 with every other digit 0.
- R10: An input transfer occurs when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high on the next cycle. `in_ready` equals (not `out_valid`) or `out_ready`.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_grade`, `out_a_larger` and `out_tie` hold their values.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can accept an operand set |
| in_a | input | 3·NDIG | First grade, redundant digits |
| in_b | input | 3·NDIG | Second grade, redundant digits |
| in_op | input | 3 | Operator select |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_grade | output | 3·NDIG | Result grade, canonical digits |
| out_a_larger | output | 1 | First grade exceeds second |
| out_tie | output | 1 | Grades equal in value |

## Verification
Random operand pairs cover all eight operator codes. Their digits are drawn from 0..4 with occasional codes 5..7, so the same value often appears under different encodings, and a per-digit comparison would report a false order or miss a tie. Directed pairs place two different encodings of one value against each other, and they put an all-fours operand against a canonical full-scale one. These cases separate value-based comparison from encoding-based comparison and test the clamp. Sums near full scale tell the saturating operators apart from plain arithmetic. Random back-pressure on the result side tests that a stalled result holds and that input acceptance follows the ready rule.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int DIG_W = 3;
  localparam int DIG_TOP = 4;

  typedef enum logic [2:0] {
    OP_MIN   = 3'd0,
    OP_MAX   = 3'd1,
    OP_BSUM  = 3'd2,
    OP_BDIFF = 3'd3,
    OP_BPROD = 3'd4
  } fz_op_e;

  typedef struct packed {
    logic a_larger;
    logic tie;
  } fz_cmp_t;
endpackage

// File: rtl/fz_pd_decode.sv
// Reduces a redundant radix-4 grade to its integer value, clamped to full scale.
module fz_pd_decode #(
  parameter int NDIG = 4,
  localparam int GW = NDIG * fz_pkg::DIG_W,
  localparam int VW = 2 * NDIG + 1,
  localparam int RW = 2 * NDIG + 2
) (
  input  logic [GW-1:0] digits_i,
  output logic [VW-1:0] value_o
);
  localparam logic [RW-1:0] FULL = RW'(1) << (2 * NDIG);

  logic [RW-1:0] part [NDIG+1];
  assign part[0] = '0;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [2:0] raw;
    logic [2:0] dig;
    assign raw = digits_i[fz_pkg::DIG_W*i +: fz_pkg::DIG_W];
    // codes above the top digit saturate to it
    assign dig = (raw > 3'(fz_pkg::DIG_TOP)) ? 3'(fz_pkg::DIG_TOP) : raw;
    assign part[i+1] = part[i] + (RW'(dig) << (2 * i));
  end

  assign value_o = (part[NDIG] > FULL) ? FULL[VW-1:0] : part[NDIG][VW-1:0];
endmodule

// File: rtl/fz_pd_encode.sv
// Writes an integer grade (0..full scale) in canonical radix-4 digits.
module fz_pd_encode #(
  parameter int NDIG = 4,
  localparam int GW = NDIG * fz_pkg::DIG_W,
  localparam int VW = 2 * NDIG + 1
) (
  input  logic [VW-1:0] value_i,
  output logic [GW-1:0] digits_o
);
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    if (i == NDIG - 1) begin : g_top
      // full scale carries into the top digit as the value 4
      assign digits_o[fz_pkg::DIG_W*i +: fz_pkg::DIG_W] =
        value_i[VW-1] ? 3'(fz_pkg::DIG_TOP) : {1'b0, value_i[2*i +: 2]};
    end else begin : g_low
      assign digits_o[fz_pkg::DIG_W*i +: fz_pkg::DIG_W] = {1'b0, value_i[2*i +: 2]};
    end
  end
endmodule

// File: rtl/fz_op_core.sv
// Value comparison and saturating fuzzy operators on clamped integer grades.
module fz_op_core
  import fz_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int VW = 2 * NDIG + 1
) (
  input  logic [VW-1:0] a_i,
  input  logic [VW-1:0] b_i,
  input  logic [2:0]    op_i,
  output logic [VW-1:0] res_o,
  output fz_cmp_t       cmp_o
);
  localparam logic [VW:0] FULL = (VW+1)'(1) << (2 * NDIG);

  logic [VW:0]   sum;
  logic [VW-1:0] bsum, bdiff, bprod, lo, hi;
  logic          a_gt;

  assign a_gt  = a_i > b_i;
  assign lo    = a_gt ? b_i : a_i;
  assign hi    = a_gt ? a_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_i};
  assign bsum  = (sum > FULL) ? FULL[VW-1:0] : sum[VW-1:0];
  assign bdiff = a_gt ? (a_i - b_i) : '0;

  always_comb begin
    logic [VW:0] over;
    over  = sum - FULL;
    bprod = (sum > FULL) ? over[VW-1:0] : '0;
  end

  always_comb begin
    case (op_i)
      OP_MIN:   res_o = lo;
      OP_MAX:   res_o = hi;
      OP_BSUM:  res_o = bsum;
      OP_BDIFF: res_o = bdiff;
      OP_BPROD: res_o = bprod;
      default:  res_o = '0;
    endcase
  end

  assign cmp_o.a_larger = a_gt;
  assign cmp_o.tie      = a_i == b_i;
endmodule

// File: rtl/fz_grade_unit.sv
module fz_grade_unit
  import fz_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int GW = NDIG * DIG_W,
  localparam int VW = 2 * NDIG + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [GW-1:0] in_a,
  input  logic [GW-1:0] in_b,
  input  logic [2:0]    in_op,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [GW-1:0] out_grade,
  output logic          out_a_larger,
  output logic          out_tie
);
  logic [VW-1:0] val_a, val_b, val_r;
  logic [GW-1:0] enc_r;
  fz_cmp_t       cmp;
  logic          take;

  fz_pd_decode #(.NDIG(NDIG)) u_dec_a (.digits_i(in_a), .value_o(val_a));
  fz_pd_decode #(.NDIG(NDIG)) u_dec_b (.digits_i(in_b), .value_o(val_b));

  fz_op_core #(.NDIG(NDIG)) u_core (
    .a_i(val_a), .b_i(val_b), .op_i(in_op), .res_o(val_r), .cmp_o(cmp)
  );

  fz_pd_encode #(.NDIG(NDIG)) u_enc (.value_i(val_r), .digits_o(enc_r));

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_grade    <= '0;
      out_a_larger <= 1'b0;
      out_tie      <= 1'b0;
    end else begin
      if (take) begin
        out_valid    <= 1'b1;
        out_grade    <= enc_r;
        out_a_larger <= cmp.a_larger;
        out_tie      <= cmp.tie;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_grade)
      && $stable(out_a_larger) && $stable(out_tie));

  // R10
  accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_a_larger && out_tie));

  // R9
  full_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_grade[GW-1 -: DIG_W] == 3'(DIG_TOP) |-> out_grade[GW-DIG_W-1:0] == '0);

  // R9
  top_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_grade[GW-1 -: DIG_W] <= 3'(DIG_TOP));

  for (genvar i = 0; i < NDIG - 1; i++) begin : g_lowchk
    // R9
    low_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_grade[DIG_W*i + 2]);
  end
endmodule

// File: tb/fz_grade_unit_test.sv
module fz_grade_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 4;
  localparam int GW = NDIG * 3;
  localparam int FULL = 4 ** NDIG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [GW-1:0] in_a = '0;
  logic [GW-1:0] in_b = '0;
  logic [2:0] in_op = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [GW-1:0] out_grade;
  logic out_a_larger, out_tie;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int acc_at = -1;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  logic [GW-1:0] q_g[$];
  logic          q_gt[$];
  logic          q_tie[$];
  string         q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fz_grade_unit #(.NDIG(NDIG)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_grade(out_grade),
    .out_a_larger(out_a_larger), .out_tie(out_tie)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1 value model: digit codes above 4 count as 4, clamp to full scale
  function automatic int dec(input logic [GW-1:0] g);
    int s = 0;
    for (int i = 0; i < NDIG; i++) begin
      int d = int'(g[3*i +: 3]);
      if (d > 4) d = 4;
      s += d * (4 ** i);
    end
    return (s > FULL) ? FULL : s;
  endfunction

  // R9 canonical form
  function automatic logic [GW-1:0] enc(input int v);
    logic [GW-1:0] g = '0;
    if (v >= FULL) g[GW-1 -: 3] = 3'd4;
    else for (int i = 0; i < NDIG; i++) g[3*i +: 3] = 3'((v >> (2*i)) & 3);
    return g;
  endfunction

  function automatic int model(input int a, input int b, input int op);
    case (op)
      0: return (a < b) ? a : b;                    // R2
      1: return (a > b) ? a : b;                    // R3
      2: return (a + b > FULL) ? FULL : a + b;      // R4
      3: return (a > b) ? a - b : 0;                // R5
      4: return (a + b > FULL) ? a + b - FULL : 0;  // R6
      default: return 0;                            // R7
    endcase
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic send(input logic [GW-1:0] a, input logic [GW-1:0] b,
                      input int op, input string pre);
    int va, vb;
    @(negedge clk);
    in_a = a; in_b = b; in_op = 3'(op); in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    va = dec(a); vb = dec(b);
    q_g.push_back(enc(model(va, vb, op)));
    q_gt.push_back(va > vb);
    q_tie.push_back(va == vb);
    q_tag.push_back({pre, op_tag(op), " R9"});
    acc_at = cyc + 1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [GW-1:0] rand_grade(input bit wild);
    logic [GW-1:0] g;
    for (int i = 0; i < NDIG; i++)
      g[3*i +: 3] = wild ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 4));
    return g;
  endfunction

  // back-pressure driver
  always @(negedge clk) out_ready <= stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;

  // monitor / scoreboard
  logic          prev_stall = 1'b0;
  logic [GW-1:0] prev_g = '0;
  logic          prev_gt = 1'b0, prev_tie = 1'b0;
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      // R10 ready rule
      check(in_ready == (!out_valid || out_ready), "R10 ready", int'(in_ready),
            int'(!out_valid || out_ready));
      if (cyc == acc_at) check(out_valid, "R10 latency", int'(out_valid), 1);
      if (prev_stall) begin
        check(out_valid && out_grade == prev_g && out_a_larger == prev_gt
              && out_tie == prev_tie, "R11 hold", int'(out_grade), int'(prev_g));
      end
      if (out_valid && out_ready) begin
        if (q_g.size() == 0) begin
          check(1'b0, "R10 unexpected result", int'(out_grade), -1);
        end else begin
          logic [GW-1:0] eg;
          logic egt, etie;
          string tg;
          eg = q_g.pop_front(); egt = q_gt.pop_front();
          etie = q_tie.pop_front(); tg = q_tag.pop_front();
          check(out_grade == eg, tg, int'(out_grade), int'(eg));
          check(out_a_larger == egt && out_tie == etie, "R8 flags",
                int'({out_a_larger, out_tie}), int'({egt, etie}));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_g = out_grade; prev_gt = out_a_larger; prev_tie = out_tie;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check(!out_valid, "R12 out_valid", int'(out_valid), 0);
    check(in_ready, "R12 in_ready", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: same value 4 written two ways
    send(12'(3'd4), 12'(3'd1 << 3), 0, "");
    send(12'(3'd4), 12'(3'd1 << 3), 1, "");
    // R1: all fours clamp to full scale, tie with canonical full scale
    send({4{3'd4}}, {3'd4, 9'd0}, 0, "R1 ");
    send({4{3'd4}}, {3'd4, 9'd0}, 2, "R1 ");
    // R1: digit codes 5..7 saturate to 4
    send({3'd0, 3'd0, 3'd7, 3'd5}, {3'd0, 3'd0, 3'd4, 3'd4}, 3, "R1 ");
    // bounded ops at the full-scale edge
    send(enc(200), enc(56), 2, "");
    send(enc(200), enc(57), 4, "");
    send(enc(200), enc(56), 4, "");
    send(enc(10), enc(30), 3, "");
    // R7: codes 5..7 give zero
    send(enc(100), enc(90), 5, "");
    send(enc(100), enc(90), 6, "");
    send(enc(255), enc(255), 7, "");

    for (int n = 0; n < 300; n++)
      send(rand_grade(n % 5 == 0), rand_grade(n % 7 == 0), $urandom_range(0, 7),
           (n % 5 == 0) ? "R1 " : "");
    stall_mode = 1'b1;
    for (int n = 0; n < 300; n++)
      send(rand_grade(n % 4 == 0), rand_grade(1'b0), $urandom_range(0, 7),
           (n % 4 == 0) ? "R1 " : "");
    idle();
    stall_mode = 1'b0;
    for (int k = 0; k < 50 && q_g.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q_g.size() == 0, "R10 drain", q_g.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule